// File: doc/BRIEF.md
# Processor Clock State Sequencer

This block follows a processor through its low-power clock states and times the way out of each one. It runs on a free-running clock whose period equals one bus clock. Every exit latency is therefore a count of these cycles. The states it tracks are Normal, Auto Halt, Stop Grant, Quick Start, HALT/Grant Snoop, Sleep and Deep Sleep.

Its inputs are:
- a software halt request;
- an active-low stop-clock request;
- a snoop request;
- a sleep request;
- a pair that reports whether the bus reference clock is running and at which level it rests;
- a synchronous active-low reset.

Its outputs are:
- the current state code;
- a flag that says whether snoops can be serviced;
- a one-cycle ready pulse after each timed exit;
- a sticky flag for an illegal reset taken in Deep Sleep.

A parameter selects which state a stop-clock request leads to: Stop Grant, or Quick Start on modules that lack Stop Grant and Sleep. A second parameter sets the long relock wait after the reference clock restarts.

Top module: `clkstate_seq`

## Requirements
- R1: State codes on `state_o` are Normal=0, Auto Halt=1, Stop Grant=2, Quick Start=3, HALT/Grant Snoop=4, Sleep=5, Deep Sleep=6; code 7 never appears. Reset sampled low in any state but Deep Sleep gives state 0, `ready_o`=0, `rst_err_o`=0 and a cleared countdown at the next edge.
- R2: In Normal, `stop_req_n`=0 moves the block at the next edge to Stop Grant, or to Quick Start when QS_MODE=1. This takes priority over `halt_req`=1, which otherwise moves it to Auto Halt.
- R3: In Auto Halt, `halt_req` first sampled low at edge k gives Normal at edge k+EXIT_LAT (default 10).
- R4: In Stop Grant, `sleep_req`=1 gives Sleep at the next edge. Otherwise `stop_req_n` sampled high at edge k gives Normal at edge k+EXIT_LAT.
- R5: In Sleep, `sleep_req` sampled low at edge k gives Stop Grant at edge k+EXIT_LAT.
- R6: In Quick Start, `snoop_req`=1 gives HALT/Grant Snoop at the next edge. `stop_req_n` sampled high at edge k gives Normal at edge k+EXIT_LAT.
- R7: HALT/Grant Snoop returns to the state it came from SNOOP_TAIL edges (default 3) after the first edge that samples `snoop_req` low. A snoop request seen during that tail restarts it.
- R8: `snoop_ok_o` is 1 in states 0 to 4 and 0 in states 5 and 6. A snoop request moves Auto Halt, Stop Grant and Quick Start to HALT/Grant Snoop, leaves Normal unchanged, and is ignored in Sleep.
- R9: Deep Sleep is entered only from Sleep or Quick Start, and only at an edge that samples `ref_run`=0 with `ref_lvl`=0. With `ref_run`=0 and `ref_lvl`=1, the state does not change.
- R10: Deep Sleep returns to the state it came from after RELOCK_CYC consecutive edges that sample `ref_run`=1. A sample of 0 restarts the wait.
- R11: `ready_o` is 1 for exactly the first cycle of the state that a timed exit (R3 to R7, R10) leads to, and 0 at all other times.
- R12: Reset sampled in Deep Sleep keeps the state and restarts any relock wait, and sets `rst_err_o`. That flag stays set until reset is sampled in another state.
- R13: Once an exit countdown has started, reversing the request that started it does not cancel it. Only a snoop detour, loss of the reference clock, or reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, one cycle per bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| halt_req | input | 1 | Software halt request |
| stop_req_n | input | 1 | Stop-clock request, active low |
| snoop_req | input | 1 | Snoop request |
| sleep_req | input | 1 | Sleep request |
| ref_run | input | 1 | Bus reference clock is running |
| ref_lvl | input | 1 | Level at which the reference clock rests |
| state_o | output | 3 | Current state code (R1) |
| snoop_ok_o | output | 1 | Snoops can be serviced in this state |
| ready_o | output | 1 | One-cycle pulse after a timed exit |
| rst_err_o | output | 1 | Reset was taken in Deep Sleep (sticky) |

## Verification
The bench counts exit timing on both sides of the edge. A design that is off by one would show the new state a cycle early, or would still hold the old one when the bench samples. Snoop tails that are cut short by a new request must restart from zero; a design that resumes the old count returns one or two cycles too soon. The bench also stops the reference clock while it rests high, to catch a design that enters Deep Sleep anyway. It restarts the clock and drops it again during relock, to catch a design that keeps counting across the gap. It asserts reset in Deep Sleep, to catch a design that drops to Normal instead of flagging the error. A second instance with Quick Start selected, and a reference model driven by random requests, cover the ordering between snoop detours, committed exits and resets.

// File: rtl/clkst_pkg.sv
package clkst_pkg;

  typedef enum logic [2:0] {
    CS_RUN    = 3'd0,
    CS_HALT   = 3'd1,
    CS_GRANT  = 3'd2,
    CS_QSTART = 3'd3,
    CS_SNOOP  = 3'd4,
    CS_SLEEP  = 3'd5,
    CS_DEEP   = 3'd6
  } cstate_e;

  // States in which the bus may still be snooped.
  function automatic logic snoop_serviced(cstate_e s);
    case (s)
      CS_RUN, CS_HALT, CS_GRANT, CS_QSTART, CS_SNOOP: return 1'b1;
      default:                                        return 1'b0;
    endcase
  endfunction

  // States a snoop request pulls out into the snoop state.
  function automatic logic snoop_detours(cstate_e s);
    return (s == CS_HALT) || (s == CS_GRANT) || (s == CS_QSTART);
  endfunction

  // Countdown length used when leaving state s.
  function automatic int unsigned pick_wait(cstate_e s, int unsigned exit_lat,
                                            int unsigned tail, int unsigned relock);
    case (s)
      CS_SNOOP: return tail;
      CS_DEEP:  return relock;
      default:  return exit_lat;
    endcase
  endfunction

  function automatic int unsigned longest3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/clkst_cdown.sv
module clkst_cdown #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr)                cnt_q <= '0;
    else if (start)         cnt_q <= load;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));

  // R13: the sequencer never restarts a countdown that is still running.
  a_r13_start_idle: assert property (@(posedge clk) disable iff (clr)
    start |-> !busy);

endmodule

// File: rtl/clkst_refmon.sv
module clkst_refmon (
  input  logic ref_run,
  input  logic ref_lvl,
  output logic stop_low,
  output logic resumed
);
  // A stop counts for Deep Sleep only when the clock rests low.
  assign stop_low = !ref_run && !ref_lvl;
  assign resumed  = ref_run;
endmodule

// File: rtl/clkst_snoop_gate.sv
module clkst_snoop_gate
  import clkst_pkg::*;
(
  input  cstate_e state,
  input  logic    snoop_req,
  output logic    snoop_ok,
  output logic    detour
);
  assign snoop_ok = snoop_serviced(state);
  assign detour   = snoop_req && snoop_detours(state);
endmodule

// File: rtl/clkstate_seq.sv
module clkstate_seq
  import clkst_pkg::*;
#(
  parameter int unsigned EXIT_LAT   = 10,
  parameter int unsigned SNOOP_TAIL = 3,
  parameter int unsigned RELOCK_CYC = 3_000_000,
  parameter bit          QS_MODE    = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       stop_req_n,
  input  logic       snoop_req,
  input  logic       sleep_req,
  input  logic       ref_run,
  input  logic       ref_lvl,
  output logic [2:0] state_o,
  output logic       snoop_ok_o,
  output logic       ready_o,
  output logic       rst_err_o
);
  localparam int unsigned LONGEST = longest3(EXIT_LAT, SNOOP_TAIL, RELOCK_CYC);
  localparam int unsigned CW      = $clog2(LONGEST + 1);

  cstate_e state_q, nxt_state, ret_q, nxt_ret, stop_tgt;
  logic    ready_q, rst_err_q;
  logic    t_start, t_abort, t_busy, t_done, exit_done;
  logic    snoop_ok, detour, stop_low, resumed;
  logic [CW-1:0] t_load;

  generate
    if (QS_MODE) begin : g_qstart
      assign stop_tgt = CS_QSTART;
    end else begin : g_grant
      assign stop_tgt = CS_GRANT;
    end
  endgenerate

  clkst_snoop_gate u_gate (
    .state(state_q), .snoop_req(snoop_req), .snoop_ok(snoop_ok), .detour(detour)
  );

  clkst_refmon u_ref (
    .ref_run(ref_run), .ref_lvl(ref_lvl), .stop_low(stop_low), .resumed(resumed)
  );

  assign t_load = CW'(pick_wait(state_q, EXIT_LAT, SNOOP_TAIL, RELOCK_CYC));

  clkst_cdown #(.CW(CW)) u_cnt (
    .clk(clk), .clr(!rst_n || t_abort), .start(t_start && rst_n),
    .load(t_load), .busy(t_busy), .done(t_done)
  );

  always_comb begin
    nxt_state = state_q;
    nxt_ret   = ret_q;
    t_start   = 1'b0;
    t_abort   = 1'b0;
    exit_done = 1'b0;
    case (state_q)
      CS_RUN: begin
        if (!stop_req_n)   nxt_state = stop_tgt;
        else if (halt_req) nxt_state = CS_HALT;
      end
      CS_HALT: begin
        if (detour) begin
          t_abort = 1'b1; nxt_state = CS_SNOOP; nxt_ret = CS_HALT;
        end else if (t_done) begin
          nxt_state = CS_RUN; exit_done = 1'b1;
        end else if (!t_busy && !halt_req) begin
          t_start = 1'b1;
        end
      end
      CS_GRANT: begin
        if (detour) begin
          t_abort = 1'b1; nxt_state = CS_SNOOP; nxt_ret = CS_GRANT;
        end else if (t_done) begin
          nxt_state = CS_RUN; exit_done = 1'b1;
        end else if (!t_busy) begin
          if (sleep_req)       nxt_state = CS_SLEEP;
          else if (stop_req_n) t_start = 1'b1;
        end
      end
      CS_QSTART: begin
        if (detour) begin
          t_abort = 1'b1; nxt_state = CS_SNOOP; nxt_ret = CS_QSTART;
        end else if (t_done) begin
          nxt_state = CS_RUN; exit_done = 1'b1;
        end else if (!t_busy) begin
          if (stop_low) begin
            nxt_state = CS_DEEP; nxt_ret = CS_QSTART;
          end else if (stop_req_n) begin
            t_start = 1'b1;
          end
        end
      end
      CS_SNOOP: begin
        if (snoop_req) begin
          t_abort = 1'b1;
        end else if (t_done) begin
          nxt_state = ret_q; exit_done = 1'b1;
        end else if (!t_busy) begin
          t_start = 1'b1;
        end
      end
      CS_SLEEP: begin
        if (t_done) begin
          nxt_state = CS_GRANT; exit_done = 1'b1;
        end else if (!t_busy) begin
          if (stop_low) begin
            nxt_state = CS_DEEP; nxt_ret = CS_SLEEP;
          end else if (!sleep_req) begin
            t_start = 1'b1;
          end
        end
      end
      CS_DEEP: begin
        if (!resumed) begin
          t_abort = 1'b1;
        end else if (t_done) begin
          nxt_state = ret_q; exit_done = 1'b1;
        end else if (!t_busy) begin
          t_start = 1'b1;
        end
      end
      default: nxt_state = CS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      if (state_q == CS_DEEP) begin
        rst_err_q <= 1'b1;
      end else begin
        state_q   <= CS_RUN;
        ret_q     <= CS_RUN;
        rst_err_q <= 1'b0;
      end
    end else begin
      state_q <= nxt_state;
      ret_q   <= nxt_ret;
      ready_q <= exit_done;
    end
  end

  assign state_o    = state_q;
  assign snoop_ok_o = snoop_ok;
  assign ready_o    = ready_q;
  assign rst_err_o  = rst_err_q;

  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 3'd7);

  a_r6_qs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_QSTART && snoop_req) |=> state_q == CS_SNOOP);

  a_r8_sleep_no_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_SLEEP && snoop_req) |=> state_q != CS_SNOOP);

  a_r9_deep_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_DEEP && $past(state_q) != CS_DEEP)
      |-> ($past(state_q) == CS_SLEEP || $past(state_q) == CS_QSTART));

  a_r9_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_SLEEP && !ref_run && ref_lvl && sleep_req && !t_busy)
      |=> state_q == CS_SLEEP);

  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> !ready_q);

  a_r12_deep_reset: assert property (@(posedge clk)
    (state_q == CS_DEEP && !rst_n) |=> (state_q == CS_DEEP && rst_err_q));

endmodule

// File: tb/clkstate_seq_ref.sv
module clkstate_seq_ref #(
  parameter bit QS   = 1'b0,
  parameter int EXIT = 10,
  parameter int TAIL = 3,
  parameter int RELK = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt,
  input  logic       stopn,
  input  logic       snoop,
  input  logic       sleep,
  input  logic       rrun,
  input  logic       rlvl,
  output logic [2:0] st,
  output logic       sok,
  output logic       rdy,
  output logic       err
);
  int s = 0, r = 0, w = 0;
  bit rd = 0, e = 0;

  always @(posedge clk) begin
    rd = 0;
    if (!rst_n) begin
      w = 0;
      if (s == 6) e = 1;
      else begin s = 0; r = 0; e = 0; end
    end else begin
      case (s)
        0: if (!stopn) s = QS ? 3 : 2; else if (halt) s = 1;
        1, 2, 3: begin
          if (snoop) begin w = 0; r = s; s = 4; end
          else if (w > 0) begin w = w - 1; if (w == 0) begin s = 0; rd = 1; end end
          else if (s == 1 && !halt) w = EXIT;
          else if (s == 2 && sleep) s = 5;
          else if (s == 2 && stopn) w = EXIT;
          else if (s == 3 && !rrun && !rlvl) begin r = 3; s = 6; end
          else if (s == 3 && stopn) w = EXIT;
        end
        4: begin
          if (snoop) w = 0;
          else if (w > 0) begin w = w - 1; if (w == 0) begin s = r; rd = 1; end end
          else w = TAIL;
        end
        5: begin
          if (w > 0) begin w = w - 1; if (w == 0) begin s = 2; rd = 1; end end
          else if (!rrun && !rlvl) begin r = 5; s = 6; end
          else if (!sleep) w = EXIT;
        end
        default: begin
          if (!rrun) w = 0;
          else if (w > 0) begin w = w - 1; if (w == 0) begin s = r; rd = 1; end end
          else w = RELK;
        end
      endcase
    end
    st  = 3'(s);
    sok = (s <= 4);
    rdy = rd;
    err = e;
  end
endmodule

// File: tb/clkstate_seq_bench.sv
module clkstate_seq_bench;
  localparam int EXIT = 10, TAIL = 3, RELK = 40;

  logic clk = 0;
  always #10 clk = ~clk;

  logic rst_n = 0, halt = 0, stopn = 1, snoop = 0, sleep = 0, rrun = 1, rlvl = 0;
  logic [2:0] a_st, b_st, ma_st, mb_st;
  logic a_sok, a_rdy, a_err, b_sok, b_rdy, b_err;
  logic ma_sok, ma_rdy, ma_err, mb_sok, mb_rdy, mb_err;

  clkstate_seq #(.EXIT_LAT(EXIT), .SNOOP_TAIL(TAIL), .RELOCK_CYC(RELK), .QS_MODE(1'b0)) u_clkstate_seq (
    .clk(clk), .rst_n(rst_n), .halt_req(halt), .stop_req_n(stopn), .snoop_req(snoop),
    .sleep_req(sleep), .ref_run(rrun), .ref_lvl(rlvl),
    .state_o(a_st), .snoop_ok_o(a_sok), .ready_o(a_rdy), .rst_err_o(a_err));

  clkstate_seq #(.EXIT_LAT(EXIT), .SNOOP_TAIL(TAIL), .RELOCK_CYC(RELK), .QS_MODE(1'b1)) u_clkstate_seq_qs (
    .clk(clk), .rst_n(rst_n), .halt_req(halt), .stop_req_n(stopn), .snoop_req(snoop),
    .sleep_req(sleep), .ref_run(rrun), .ref_lvl(rlvl),
    .state_o(b_st), .snoop_ok_o(b_sok), .ready_o(b_rdy), .rst_err_o(b_err));

  clkstate_seq_ref #(.QS(1'b0), .EXIT(EXIT), .TAIL(TAIL), .RELK(RELK)) u_ref_a (
    .clk(clk), .rst_n(rst_n), .halt(halt), .stopn(stopn), .snoop(snoop), .sleep(sleep),
    .rrun(rrun), .rlvl(rlvl), .st(ma_st), .sok(ma_sok), .rdy(ma_rdy), .err(ma_err));

  clkstate_seq_ref #(.QS(1'b1), .EXIT(EXIT), .TAIL(TAIL), .RELK(RELK)) u_ref_b (
    .clk(clk), .rst_n(rst_n), .halt(halt), .stopn(stopn), .snoop(snoop), .sleep(sleep),
    .rrun(rrun), .rlvl(rlvl), .st(mb_st), .sok(mb_sok), .rdy(mb_rdy), .err(mb_err));

  int checks = 0, errors = 0;
  bit finished = 0, cmp_en = 0;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic string st_tag(input int s);
    case (s)
      0: return "R2 normal";
      1: return "R3 auto halt";
      2: return "R4 stop grant";
      3: return "R6 quick start";
      4: return "R7 snoop state";
      5: return "R5 sleep";
      default: return "R10 deep sleep";
    endcase
  endfunction

  // Every cycle: both instances against their reference models.
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(a_st, ma_st, {st_tag(ma_st), " (A)"});
      chk(a_sok, ma_sok, "R8 snoop_ok (A)");
      chk(a_rdy, ma_rdy, "R11 ready (A)");
      chk(a_err, ma_err, "R12 error flag (A)");
      chk(b_st, mb_st, {st_tag(mb_st), " (B)"});
      chk(b_sok, mb_sok, "R8 snoop_ok (B)");
      chk(b_rdy, mb_rdy, "R11 ready (B)");
      chk(b_err, mb_err, "R12 error flag (B)");
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state
    tick(3);
    chk(a_st, 0, "R1 reset state");
    chk(a_rdy, 0, "R1 reset ready");
    chk(a_err, 0, "R1 reset error");
    chk(a_sok, 1, "R8 snoop allowed in normal");
    rst_n = 1;
    cmp_en = 1;

    // Auto Halt entry and timed exit
    halt = 1; tick(1); chk(a_st, 1, "R2 halt entry");
    halt = 0; tick(EXIT); chk(a_st, 1, "R3 still halted");
    tick(1); chk(a_st, 0, "R3 exit to normal"); chk(a_rdy, 1, "R11 ready after halt exit");
    tick(1); chk(a_rdy, 0, "R11 ready one cycle");

    // Stop beats halt; committed exit
    halt = 1; stopn = 0; tick(1); chk(a_st, 2, "R2 stop over halt");
    halt = 0;
    stopn = 1; tick(3); stopn = 0; tick(EXIT - 3); chk(a_st, 2, "R13 still granting");
    tick(1); chk(a_st, 0, "R13 committed exit"); chk(a_rdy, 1, "R13 ready");
    tick(1); chk(a_st, 2, "R2 stop grant again");

    // Snoop detour from Stop Grant, with tail restart
    snoop = 1; tick(1); chk(a_st, 4, "R8 detour"); chk(a_sok, 1, "R8 snoop ok in detour");
    tick(2); chk(a_st, 4, "R7 held while snooping");
    snoop = 0; tick(TAIL); chk(a_st, 4, "R7 tail");
    tick(1); chk(a_st, 2, "R7 return to grant"); chk(a_rdy, 1, "R11 ready after snoop");
    snoop = 1; tick(1); chk(a_st, 4, "R8 detour again");
    snoop = 0; tick(2); snoop = 1; tick(1); chk(a_st, 4, "R7 reasserted");
    snoop = 0; tick(TAIL); chk(a_st, 4, "R7 tail restarted");
    tick(1); chk(a_st, 2, "R7 return after restart");

    // Sleep, snoop ignored, stop high ignored, Deep Sleep
    sleep = 1; tick(1); chk(a_st, 5, "R4 sleep entry"); chk(a_sok, 0, "R8 no snoop in sleep");
    snoop = 1; tick(2); chk(a_st, 5, "R8 snoop ignored in sleep"); snoop = 0;
    rrun = 0; rlvl = 1; tick(3); chk(a_st, 5, "R9 stopped high ignored");
    rlvl = 0; tick(1); chk(a_st, 6, "R9 deep entry"); chk(a_sok, 0, "R8 no snoop in deep");

    // Illegal reset in Deep Sleep
    rst_n = 0; tick(2); chk(a_st, 6, "R12 state kept"); chk(a_err, 1, "R12 error set");
    rst_n = 1; tick(1); chk(a_err, 1, "R12 error sticky");

    // Relock with an interruption
    rrun = 1; tick(20); rrun = 0; tick(2); chk(a_st, 6, "R10 clock lost");
    rrun = 1; tick(RELK); chk(a_st, 6, "R10 relocking");
    tick(1); chk(a_st, 5, "R10 back to sleep"); chk(a_rdy, 1, "R11 ready after relock");

    // Sleep and grant exits
    sleep = 0; tick(EXIT); chk(a_st, 5, "R5 still sleeping");
    tick(1); chk(a_st, 2, "R5 to stop grant");
    stopn = 1; tick(EXIT); chk(a_st, 2, "R4 still granting");
    tick(1); chk(a_st, 0, "R4 exit to normal");
    rst_n = 0; tick(1); chk(a_st, 0, "R12 reset outside deep"); chk(a_err, 0, "R12 error cleared");
    chk(b_st, 0, "R1 quick instance reset");
    rst_n = 1; tick(1);

    // Quick Start variant
    stopn = 0; tick(1); chk(b_st, 3, "R2 quick start entry"); chk(a_st, 2, "R2 grant entry");
    snoop = 1; tick(1); chk(b_st, 4, "R6 snoop from quick start");
    snoop = 0; tick(TAIL); chk(b_st, 4, "R7 tail in quick mode");
    tick(1); chk(b_st, 3, "R7 back to quick start");
    rrun = 0; rlvl = 0; tick(1); chk(b_st, 6, "R9 deep from quick start");
    chk(a_st, 2, "R9 grant ignores clock stop");
    rrun = 1; tick(RELK); chk(b_st, 6, "R10 quick relocking");
    tick(1); chk(b_st, 3, "R10 back to quick start");
    stopn = 1; tick(EXIT); chk(b_st, 3, "R6 still quick start");
    tick(1); chk(b_st, 0, "R6 exit to normal"); chk(a_st, 0, "R4 grant exit");

    // Random phase, checked against the reference models
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(15) == 0) halt = ~halt;
      if ($urandom_range(15) == 0) stopn = ~stopn;
      if ($urandom_range(15) == 0) sleep = ~sleep;
      if ($urandom_range(7) == 0) snoop = ~snoop;
      if ($urandom_range(63) == 0) begin
        rrun = ~rrun;
        if (!rrun) rlvl = 1'($urandom_range(1));
      end
      rst_n = ($urandom_range(499) != 0);
      tick(1);
    end

    finished = 1;
    cmp_en = 0;
    summary();
    $finish;
  end
endmodule